// File: doc/BRIEF.md
# Reservation Station Group with Result-Bus Operand Capture

This block holds a small set of waiting operations for one class of execution unit, three entries by default. Issue logic hands it an operation code and two source operands. Each source arrives either as a value or as the nonzero tag of the station that will later produce it. The block places the operation in the lowest-numbered free entry and reports that entry's tag. The tag is how later consumers refer to the result.

On every cycle, each operand that is still waiting compares its producer tag with the tag on the shared result bus. On a match it copies the data and clears its tag, and a tag of zero means the operand is ready. Once both operands of an entry are ready, the entry can be sent to the execution unit. Only one entry is sent per cycle: the lowest-numbered ready entry, and only when the unit accepts it. An entry that has been sent stays occupied until a result carrying its own tag appears on the bus, and then it becomes free.

Top module: `rs_group`

## Requirements
- R1: After reset every entry is free, `iss_ready_o` is 1, `iss_tag_o` is the first entry's tag, and `fu_valid_o` is 0.
- R2: Entry i has tag BASE_TAG+i (1, 2, 3 by default). An issue goes to the lowest-numbered free entry, and `iss_tag_o` shows that entry's tag in the issue cycle. When every entry is occupied, `iss_ready_o` is 0 and an issue request is ignored.
- R3: A source given with tag 0 is stored as ready with the supplied value.
- R4: An entry is offered to the unit only while both its operand tags are 0. `fu_op_o`, `fu_a_o`, `fu_b_o` and `fu_tag_o` then carry its operation, its two values and its tag.
- R5: When `cdb_valid_i` is high and `cdb_tag_i` equals a waiting operand's nonzero tag, that operand takes `cdb_data_i` at the clock edge and becomes ready.
- R6: A source issued with a nonzero tag in the same cycle that the bus broadcasts that tag is stored as ready, holding the broadcast data.
- R7: When several entries are ready, the lowest-numbered one is offered. At most one entry is sent per cycle, and only in a cycle where `fu_ready_i` is 1. While `fu_ready_i` is 0, the offered entry stays offered.
- R8: An entry that has been sent is never offered again until it has been freed and re-issued.
- R9: A sent entry becomes free at the clock edge where the bus broadcasts its own tag.
- R10: A broadcast with tag 0, or with a tag that no waiting operand holds, changes no stored operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | OP_W | Operation code to store |
| iss_vj_i | input | DATA_W | First source value (used when its tag is 0) |
| iss_qj_i | input | TAG_W | First source producer tag, 0 = ready |
| iss_vk_i | input | DATA_W | Second source value (used when its tag is 0) |
| iss_qk_i | input | TAG_W | Second source producer tag, 0 = ready |
| iss_ready_o | output | 1 | A free entry exists |
| iss_tag_o | output | TAG_W | Tag of the entry the next issue fills |
| cdb_valid_i | input | 1 | Result bus carries a result |
| cdb_tag_i | input | TAG_W | Tag of the producing station |
| cdb_data_i | input | DATA_W | Result data |
| fu_valid_o | output | 1 | A ready entry is offered to the unit |
| fu_ready_i | input | 1 | Unit accepts the offered entry |
| fu_op_o | output | OP_W | Operation of offered entry |
| fu_a_o | output | DATA_W | First operand of offered entry |
| fu_b_o | output | DATA_W | Second operand of offered entry |
| fu_tag_o | output | TAG_W | Tag of offered entry |

## Verification
Three kinds of entry are issued together: one with both values present, one waiting on a single foreign tag, and one waiting on two different foreign tags. This shows whether readiness follows the operand tags alone, and whether a single broadcast reaches every operand that waits on it. A tag-0 broadcast and an unrelated broadcast come before the real one, so that stray captures can be told apart from correct ones. In a later round, a newly issued entry catches its producer's broadcast in the issue cycle, and so does an older, higher-numbered entry. Both then become ready together, which separates lowest-index selection from oldest-first selection and also exposes a missed same-cycle capture. Send order is held against a queue of expected operations, so a repeated send of an entry or an out-of-order send shows up as a mismatch.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Life cycle of one station slot.
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_SENT = 2'd2
  } slot_state_e;

endpackage

// File: rtl/rs_pick_low.sv
// Lowest-index selector: one-hot grant, encoded index and any flag.
module rs_pick_low #(
  parameter int N = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  always_comb begin
    grant_o = req_i & (~req_i + N'(1));
    any_o   = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/rs_operand.sv
// One source operand: a value plus a producer tag (0 = value present).
module rs_operand #(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              bus_valid_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [DATA_W-1:0] val_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              ready_o
);

  logic [DATA_W-1:0] val_q, val_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic              en;
  logic              hit_new, hit_old;

  // Bus comparisons against the incoming tag and the stored tag.
  assign hit_new = bus_valid_i && (tag_i != '0) && (bus_tag_i == tag_i);
  assign hit_old = bus_valid_i && (tag_q != '0) && (bus_tag_i == tag_q);

  always_comb begin
    val_d = val_q;
    tag_d = tag_q;
    en    = 1'b0;
    if (load_i) begin
      en = 1'b1;
      if (hit_new) begin
        val_d = bus_data_i;
        tag_d = '0;
      end else begin
        val_d = val_i;
        tag_d = tag_i;
      end
    end else if (hit_old) begin
      en    = 1'b1;
      val_d = bus_data_i;
      tag_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  tag_q <= '0;
    else if (en) tag_q <= tag_d;
  end

  // Data path register: no reset, loaded only under the enable.
  always_ff @(posedge clk) begin
    if (en) val_q <= val_d;
  end

  assign val_o   = val_q;
  assign tag_o   = tag_q;
  assign ready_o = (tag_q == '0);

  // R5: a waiting operand takes a matching broadcast.
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && bus_valid_i && tag_o != '0 && bus_tag_i == tag_o)
      |=> (tag_o == '0 && val_o == $past(bus_data_i)));

  // R6: issue and matching broadcast in one cycle.
  a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && bus_valid_i && tag_i != '0 && bus_tag_i == tag_i)
      |=> (tag_o == '0 && val_o == $past(bus_data_i)));

  // R10: a non-matching broadcast leaves a waiting operand untouched.
  a_r10_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tag_o != '0 && (!bus_valid_i || bus_tag_i != tag_o))
      |=> (tag_o == $past(tag_o)));

endmodule

// File: rtl/rs_entry.sv
// One station: state, operation code and two operands.
module rs_entry
  import rs_pkg::*;
#(
  parameter int               DATA_W    = 64,
  parameter int               TAG_W     = 4,
  parameter int               OP_W      = 4,
  parameter logic [TAG_W-1:0] ENTRY_TAG = TAG_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] vj_i,
  input  logic [TAG_W-1:0]  qj_i,
  input  logic [DATA_W-1:0] vk_i,
  input  logic [TAG_W-1:0]  qk_i,
  input  logic              bus_valid_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              launch_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] vj_o,
  output logic [DATA_W-1:0] vk_o
);

  slot_state_e     state_q, state_d;
  logic [OP_W-1:0] op_q;
  logic [TAG_W-1:0] qj, qk;
  logic            rdy_j, rdy_k;
  logic            own_result;

  rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src_j (
    .clk(clk), .rst_n(rst_n), .load_i(alloc_i), .val_i(vj_i), .tag_i(qj_i),
    .bus_valid_i(bus_valid_i), .bus_tag_i(bus_tag_i), .bus_data_i(bus_data_i),
    .val_o(vj_o), .tag_o(qj), .ready_o(rdy_j)
  );

  rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src_k (
    .clk(clk), .rst_n(rst_n), .load_i(alloc_i), .val_i(vk_i), .tag_i(qk_i),
    .bus_valid_i(bus_valid_i), .bus_tag_i(bus_tag_i), .bus_data_i(bus_data_i),
    .val_o(vk_o), .tag_o(qk), .ready_o(rdy_k)
  );

  assign own_result = bus_valid_i && (bus_tag_i == ENTRY_TAG);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SLOT_FREE: if (alloc_i)    state_d = SLOT_WAIT;
      SLOT_WAIT: if (launch_i)   state_d = SLOT_SENT;
      SLOT_SENT: if (own_result) state_d = SLOT_FREE;
      default:                   state_d = SLOT_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SLOT_FREE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (alloc_i) op_q <= op_i;
  end

  assign busy_o  = (state_q != SLOT_FREE);
  assign ready_o = (state_q == SLOT_WAIT) && rdy_j && rdy_k;
  assign op_o    = op_q;

  // R2: only a free slot is filled.
  a_r2_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> (state_q == SLOT_FREE));

  // R4: a slot leaves only with both producer tags clear.
  a_r4_launch_tags: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> (qj == '0 && qk == '0));

  // R8: a sent slot is not sent again.
  a_r8_no_resend: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_SENT) |-> !launch_i);

  // R9: own tag on the bus frees a sent slot.
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_SENT && own_result) |=> !busy_o);

endmodule

// File: rtl/rs_group.sv
// Group of stations for one execution-unit class.
module rs_group #(
  parameter int NUM_ENTRIES = 3,
  parameter int DATA_W      = 64,
  parameter int TAG_W       = 4,
  parameter int OP_W        = 4,
  parameter int BASE_TAG    = 1,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [DATA_W-1:0] iss_vj_i,
  input  logic [TAG_W-1:0]  iss_qj_i,
  input  logic [DATA_W-1:0] iss_vk_i,
  input  logic [TAG_W-1:0]  iss_qk_i,
  output logic              iss_ready_o,
  output logic [TAG_W-1:0]  iss_tag_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              fu_valid_o,
  input  logic              fu_ready_i,
  output logic [OP_W-1:0]   fu_op_o,
  output logic [DATA_W-1:0] fu_a_o,
  output logic [DATA_W-1:0] fu_b_o,
  output logic [TAG_W-1:0]  fu_tag_o
);

  localparam int N = NUM_ENTRIES;

  logic [N-1:0]      busy_vec, ready_vec;
  logic [N-1:0]      free_grant, rdy_grant;
  logic [N-1:0]      alloc_vec, launch_vec;
  logic [IDX_W-1:0]  free_idx, rdy_idx;
  logic              any_free, any_rdy;
  logic [OP_W-1:0]   op_arr [N];
  logic [DATA_W-1:0] vj_arr [N];
  logic [DATA_W-1:0] vk_arr [N];

  rs_pick_low #(.N(N)) u_pick_free (
    .req_i(~busy_vec), .grant_o(free_grant), .idx_o(free_idx), .any_o(any_free)
  );

  rs_pick_low #(.N(N)) u_pick_ready (
    .req_i(ready_vec), .grant_o(rdy_grant), .idx_o(rdy_idx), .any_o(any_rdy)
  );

  assign alloc_vec  = free_grant & {N{iss_valid_i}};
  assign launch_vec = rdy_grant  & {N{fu_ready_i}};

  for (genvar g = 0; g < N; g++) begin : g_slot
    rs_entry #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W),
      .ENTRY_TAG(TAG_W'(BASE_TAG + g))
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(alloc_vec[g]), .op_i(iss_op_i),
      .vj_i(iss_vj_i), .qj_i(iss_qj_i), .vk_i(iss_vk_i), .qk_i(iss_qk_i),
      .bus_valid_i(cdb_valid_i), .bus_tag_i(cdb_tag_i), .bus_data_i(cdb_data_i),
      .launch_i(launch_vec[g]),
      .busy_o(busy_vec[g]), .ready_o(ready_vec[g]),
      .op_o(op_arr[g]), .vj_o(vj_arr[g]), .vk_o(vk_arr[g])
    );
  end

  // AND-OR selection of the offered slot.
  always_comb begin
    fu_op_o = '0;
    fu_a_o  = '0;
    fu_b_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (rdy_grant[i]) begin
        fu_op_o = fu_op_o | op_arr[i];
        fu_a_o  = fu_a_o  | vj_arr[i];
        fu_b_o  = fu_b_o  | vk_arr[i];
      end
    end
  end

  assign iss_ready_o = any_free;
  assign iss_tag_o   = TAG_W'(BASE_TAG + int'(free_idx));
  assign fu_valid_o  = any_rdy;
  assign fu_tag_o    = TAG_W'(BASE_TAG + int'(rdy_idx));

  // R7: at most one slot sent per cycle, and none without acceptance.
  a_r7_single_send: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch_vec) && (fu_ready_i || launch_vec == '0));

  // R2: nothing is filled while the group is full.
  a_r2_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready_o |-> (alloc_vec == '0));

  // R1: groups leave reset empty.
  a_r1_reset_empty: assert property (@(posedge clk)
    $rose(rst_n) |-> (busy_vec == '0));

endmodule

// File: tb/rs_group_tb_top.sv
module rs_group_tb_top;

  logic        clk;
  logic        rst_n;
  logic        iss_valid;
  logic [3:0]  iss_op;
  logic [63:0] iss_vj, iss_vk;
  logic [3:0]  iss_qj, iss_qk;
  logic        iss_ready;
  logic [3:0]  iss_tag;
  logic        cdb_valid;
  logic [3:0]  cdb_tag;
  logic [63:0] cdb_data;
  logic        fu_valid, fu_ready;
  logic [3:0]  fu_op, fu_tag;
  logic [63:0] fu_a, fu_b;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [3:0]  tag;
    logic [3:0]  op;
    logic [63:0] a;
    logic [63:0] b;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;

  rs_group dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid_i(iss_valid), .iss_op_i(iss_op),
    .iss_vj_i(iss_vj), .iss_qj_i(iss_qj), .iss_vk_i(iss_vk), .iss_qk_i(iss_qk),
    .iss_ready_o(iss_ready), .iss_tag_o(iss_tag),
    .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_data_i(cdb_data),
    .fu_valid_o(fu_valid), .fu_ready_i(fu_ready),
    .fu_op_o(fu_op), .fu_a_o(fu_a), .fu_b_o(fu_b), .fu_tag_o(fu_tag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_issue(input logic [3:0] op, input logic [63:0] vj,
                          input logic [3:0] qj, input logic [63:0] vk,
                          input logic [3:0] qk, input logic [3:0] exp_tag,
                          input string req);
    iss_valid = 1'b1; iss_op = op;
    iss_vj = vj; iss_qj = qj; iss_vk = vk; iss_qk = qk;
    @(negedge clk);
    chk(req, "iss_ready", 64'(iss_ready), 64'd1);
    chk(req, "iss_tag", 64'(iss_tag), 64'(exp_tag));
    step();
    iss_valid = 1'b0;
  endtask

  task automatic bus_put(input logic [3:0] tag, input logic [63:0] data);
    cdb_valid = 1'b1; cdb_tag = tag; cdb_data = data;
    step();
    cdb_valid = 1'b0;
  endtask

  // Monitor: every accepted send is popped from the expected queue.
  always @(negedge clk) begin
    if (rst_n && fu_valid && fu_ready) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R8 unexpected send actual=%0h expected=none", fu_tag);
      end else begin
        mon_e = exp_q.pop_front();
        chk("R7", "send tag", 64'(fu_tag), 64'(mon_e.tag));
        chk("R4", "send op", 64'(fu_op), 64'(mon_e.op));
        chk("R5", "send a", fu_a, mon_e.a);
        chk("R5", "send b", fu_b, mon_e.b);
      end
    end
  end

  initial begin
    #(20 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; iss_valid = 1'b0; iss_op = '0;
    iss_vj = '0; iss_vk = '0; iss_qj = '0; iss_qk = '0;
    cdb_valid = 1'b0; cdb_tag = '0; cdb_data = '0; fu_ready = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1", "iss_ready", 64'(iss_ready), 64'd1);
    chk("R1", "iss_tag", 64'(iss_tag), 64'd1);
    chk("R1", "fu_valid", 64'(fu_valid), 64'd0);
    step();

    // Fill all three slots: both ready, one waiting, two waiting.
    do_issue(4'd1, 64'd10, 4'd0, 64'd20, 4'd0, 4'd1, "R2");
    do_issue(4'd2, 64'd0, 4'd9, 64'd5, 4'd0, 4'd2, "R2");
    do_issue(4'd3, 64'd0, 4'd10, 64'd0, 4'd9, 4'd3, "R2");

    // Full: request is ignored; slot 1 offered with its values.
    iss_valid = 1'b1; iss_op = 4'd15; iss_qj = '0; iss_qk = '0;
    iss_vj = 64'hdead; iss_vk = 64'hbeef;
    @(negedge clk);
    chk("R2", "iss_ready full", 64'(iss_ready), 64'd0);
    chk("R4", "fu_valid", 64'(fu_valid), 64'd1);
    chk("R3", "fu_a", fu_a, 64'd10);
    chk("R3", "fu_b", fu_b, 64'd20);
    chk("R4", "fu_tag", 64'(fu_tag), 64'd1);
    step();
    iss_valid = 1'b0;
    step();
    @(negedge clk);
    chk("R7", "held offer tag", 64'(fu_tag), 64'd1);
    step();

    // Stray broadcasts, then the real producer tag 9.
    bus_put(4'd0, 64'd555);
    bus_put(4'd7, 64'd666);
    bus_put(4'd9, 64'd100);
    @(negedge clk);
    chk("R10", "fu_a after stray", fu_a, 64'd10);
    chk("R7", "lowest offered", 64'(fu_tag), 64'd1);
    step();

    // Release the unit: slot 1 then slot 2; slot 3 still waits on 10.
    exp_q.push_back('{tag: 4'd1, op: 4'd1, a: 64'd10, b: 64'd20});
    exp_q.push_back('{tag: 4'd2, op: 4'd2, a: 64'd100, b: 64'd5});
    fu_ready = 1'b1;
    repeat (3) step();
    chk("R8", "queue drained", 64'(exp_q.size()), 64'd0);
    @(negedge clk);
    chk("R8", "no resend", 64'(fu_valid), 64'd0);
    step();

    // Result of slot 1 frees it.
    bus_put(4'd1, 64'd999);
    @(negedge clk);
    chk("R9", "iss_ready freed", 64'(iss_ready), 64'd1);
    chk("R9", "iss_tag freed", 64'(iss_tag), 64'd1);
    step();

    // Same-cycle issue and broadcast of tag 10; slot 3 also catches it.
    exp_q.push_back('{tag: 4'd1, op: 4'd4, a: 64'd77, b: 64'd8});
    exp_q.push_back('{tag: 4'd3, op: 4'd3, a: 64'd77, b: 64'd100});
    cdb_valid = 1'b1; cdb_tag = 4'd10; cdb_data = 64'd77;
    do_issue(4'd4, 64'd0, 4'd10, 64'd8, 4'd0, 4'd1, "R6");
    cdb_valid = 1'b0;
    repeat (3) step();
    chk("R6", "queue drained", 64'(exp_q.size()), 64'd0);

    // Free slots 2, 3, 1 in that order.
    bus_put(4'd2, 64'd1);
    @(negedge clk);
    chk("R9", "slot 2 first free", 64'(iss_tag), 64'd2);
    step();
    bus_put(4'd3, 64'd2);
    bus_put(4'd1, 64'd3);
    @(negedge clk);
    chk("R9", "all free tag", 64'(iss_tag), 64'd1);
    chk("R9", "all free ready", 64'(iss_ready), 64'd1);
    chk("R8", "idle", 64'(fu_valid), 64'd0);
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule